// File: doc/BRIEF.md
# In-Order Retirement Buffer with Allocate, Update and Remove Ports

The block is a circular buffer of result slots that lets out-of-order producers hand back results while consumers see them strictly in allocation order. A requester takes a slot through the allocate port and receives the slot index in return. Later, any agent holding that index writes a result through the update port. The remove port hands out the oldest slot's index and value, but only once that slot has received its result. Slot count and value width are parameters; the slot count must be a power of two.

Each port is a valid/ready style handshake: the caller raises its enable, and the transaction happens in exactly the cycle where enable and ready are both high. Holding enable while ready is low has no effect, so a caller under back-pressure simply keeps its request up until ready rises. Enables may be asserted in the same cycle on all three ports. Within a cycle the effect is as if update runs first, then remove, then allocate. This lets a full buffer retire its oldest slot and hand the freed slot to a new allocate in the same cycle. Allocate ready therefore depends combinationally on the remove enable.

Top module: `reorder_buf`

## Requirements
- R1: After a synchronous reset, allocate ready is 1, update ready and remove ready are 0, and the allocate index and remove index are both 0.
- R2: A completed allocate returns the current tail index on the allocate index output and reserves that slot as occupied and awaiting a result. The tail index then advances by one, modulo the slot count, in the next cycle.
- R3: Update ready is 1 exactly when at least one slot is occupied. A completed update to an occupied slot stores the value there and marks the slot as holding a result.
- R4: Remove ready is 1 exactly when the oldest slot is occupied and holds a result. A completed remove presents that slot's index and value, frees the slot, and advances the head index by one. Slots leave in allocation order, and a remove enable while remove ready is 0 changes nothing.
- R5: With every slot occupied, allocate ready is 0 unless remove enable is high while remove ready is high in the same cycle. In that case both operations complete and the occupancy stays at the full count.
- R6: An update completed in a cycle makes remove ready rise only from the next cycle. When an update targets the oldest slot in the same cycle as a completed remove, the remove returns the newly written value.
- R7: An update whose index names a slot that is not occupied is ignored. All ready outputs and later return values are the same as if it had not been issued.
- R8: Update, remove and allocate may all complete in one cycle, each judged ready under the update-then-remove-then-allocate order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| alloc_en | input | 1 | Allocate request |
| alloc_rdy | output | 1 | Allocate can complete this cycle |
| alloc_idx | output | IW | Slot index returned by allocate |
| upd_en | input | 1 | Update request |
| upd_rdy | output | 1 | Update can complete this cycle |
| upd_idx | input | IW | Slot index to write |
| upd_data | input | DW | Value to write |
| rem_en | input | 1 | Remove request |
| rem_rdy | output | 1 | Remove can complete this cycle |
| rem_idx | output | IW | Index of the slot being removed |
| rem_data | output | DW | Value of the slot being removed |

IW is log2 of the slot count (default 3); DW is the value width (default 16).

## Verification
Assertions check the following on every cycle:
- allocate and remove indices step by exactly one after each completion;
- occupancy never exceeds the slot count;
- update ready agrees with an occupancy tracked from the port handshakes;
- a full buffer with a firing remove offers allocate.

The reset values are also asserted.

The bench's scenarios show the rest:
- stored values come back in order with the right data;
- an update becomes visible to remove only one cycle later;
- the same-cycle bypass to the oldest slot returns the new value;
- updates to free slots are ignored;
- all three ports fire together.

These are checked against a transaction-level model under random and directed traffic.

// File: rtl/reorder_buf_pkg.sv
package reorder_buf_pkg;
  // Per-cycle completion flags for the three ports
  typedef struct packed {
    logic alloc;
    logic upd;
    logic rem;
  } rb_fire_t;
endpackage

// File: rtl/reorder_buf_ctrl.sv
module reorder_buf_ctrl
  import reorder_buf_pkg::*;
#(
  parameter int DEPTH = 8,
  localparam int IW = $clog2(DEPTH),
  localparam int CW = IW + 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          alloc_en,
  input  logic          upd_en,
  input  logic          rem_en,
  input  logic          head_done,
  output logic          alloc_rdy,
  output logic          upd_rdy,
  output logic          rem_rdy,
  output rb_fire_t      fire,
  output logic [IW-1:0] head,
  output logic [IW-1:0] tail
);
  logic [IW-1:0] head_q, tail_q;
  logic [CW-1:0] occ_q;
  logic          full;

  assign full      = (occ_q == CW'(DEPTH));
  assign rem_rdy   = head_done;
  assign upd_rdy   = (occ_q != '0);
  assign fire.rem  = rem_en & head_done;
  // remove happens before allocate inside a cycle
  assign alloc_rdy = ~full | fire.rem;
  assign fire.alloc = alloc_en & alloc_rdy;
  assign fire.upd  = upd_en & upd_rdy;

  always_ff @(posedge clk) begin
    if (rst) begin
      head_q <= '0;
      tail_q <= '0;
      occ_q  <= '0;
    end else begin
      if (fire.alloc) tail_q <= tail_q + IW'(1);
      if (fire.rem)   head_q <= head_q + IW'(1);
      case ({fire.alloc, fire.rem})
        2'b10:   occ_q <= occ_q + CW'(1);
        2'b01:   occ_q <= occ_q - CW'(1);
        default: occ_q <= occ_q;
      endcase
    end
  end

  assign head = head_q;
  assign tail = tail_q;
endmodule

// File: rtl/reorder_buf_store.sv
module reorder_buf_store
  import reorder_buf_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int DW = 16,
  localparam int IW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst,
  input  rb_fire_t      fire,
  input  logic [IW-1:0] head,
  input  logic [IW-1:0] tail,
  input  logic [IW-1:0] upd_idx,
  input  logic [DW-1:0] upd_data,
  output logic          head_done,
  output logic [DW-1:0] rem_data
);
  logic [DEPTH-1:0] vld_q, done_q;
  logic [DW-1:0]    data_q [DEPTH];
  logic [DEPTH-1:0] sel_alloc, sel_rem, sel_upd;
  logic             upd_hit;

  // an update lands only on an occupied slot
  assign upd_hit = fire.upd & vld_q[upd_idx];

  for (genvar i = 0; i < DEPTH; i++) begin : g_sel
    assign sel_alloc[i] = fire.alloc & (tail == IW'(i));
    assign sel_rem[i]   = fire.rem & (head == IW'(i));
    assign sel_upd[i]   = upd_hit & (upd_idx == IW'(i));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      vld_q  <= '0;
      done_q <= '0;
    end else begin
      for (int i = 0; i < DEPTH; i++) begin
        if (sel_alloc[i]) begin
          vld_q[i]  <= 1'b1;
          done_q[i] <= 1'b0;
        end else if (sel_rem[i]) begin
          vld_q[i]  <= 1'b0;
          done_q[i] <= 1'b0;
        end else if (sel_upd[i]) begin
          done_q[i] <= 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < DEPTH; i++) begin
      if (sel_upd[i]) data_q[i] <= upd_data;
    end
  end

  assign head_done = vld_q[head] & done_q[head];
  // update precedes remove: forward a same-cycle write to the oldest slot
  assign rem_data  = (upd_hit && upd_idx == head) ? upd_data : data_q[head];
endmodule

// File: rtl/reorder_buf.sv
module reorder_buf
  import reorder_buf_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int DW = 16,
  localparam int IW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          alloc_en,
  output logic          alloc_rdy,
  output logic [IW-1:0] alloc_idx,
  input  logic          upd_en,
  output logic          upd_rdy,
  input  logic [IW-1:0] upd_idx,
  input  logic [DW-1:0] upd_data,
  input  logic          rem_en,
  output logic          rem_rdy,
  output logic [IW-1:0] rem_idx,
  output logic [DW-1:0] rem_data
);
  rb_fire_t      fire;
  logic [IW-1:0] head, tail;
  logic          head_done;

  reorder_buf_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk(clk), .rst(rst),
    .alloc_en(alloc_en), .upd_en(upd_en), .rem_en(rem_en),
    .head_done(head_done),
    .alloc_rdy(alloc_rdy), .upd_rdy(upd_rdy), .rem_rdy(rem_rdy),
    .fire(fire), .head(head), .tail(tail)
  );

  reorder_buf_store #(.DEPTH(DEPTH), .DW(DW)) u_store (
    .clk(clk), .rst(rst), .fire(fire),
    .head(head), .tail(tail),
    .upd_idx(upd_idx), .upd_data(upd_data),
    .head_done(head_done), .rem_data(rem_data)
  );

  assign alloc_idx = tail;
  assign rem_idx   = head;
endmodule

// File: rtl/reorder_buf_checker.sv
module reorder_buf_checker #(
  parameter int DEPTH = 8,
  localparam int IW = $clog2(DEPTH),
  localparam int CW = IW + 1
) (
  input logic          clk,
  input logic          rst,
  input logic          alloc_en,
  input logic          alloc_rdy,
  input logic [IW-1:0] alloc_idx,
  input logic          upd_rdy,
  input logic          rem_en,
  input logic          rem_rdy,
  input logic [IW-1:0] rem_idx
);
  logic          a_fire, r_fire;
  logic [CW-1:0] occ_c;
  logic          rst_seen;

  assign a_fire = alloc_en & alloc_rdy;
  assign r_fire = rem_en & rem_rdy;

  always_ff @(posedge clk) begin
    if (rst) occ_c <= '0;
    else if (a_fire && !r_fire) occ_c <= occ_c + CW'(1);
    else if (r_fire && !a_fire) occ_c <= occ_c - CW'(1);
  end

  always_ff @(posedge clk) begin
    rst_seen <= rst;
    if (rst_seen && !rst) begin
      AST_RESET_STATE: assert (alloc_rdy && !upd_rdy && !rem_rdy && alloc_idx == '0 && rem_idx == '0); // R1
    end
  end

  AST_ALLOC_STEP: assert property (@(posedge clk) disable iff (rst)
    a_fire |=> alloc_idx == $past(alloc_idx) + IW'(1)); // R2

  AST_REM_STEP: assert property (@(posedge clk) disable iff (rst)
    r_fire |=> rem_idx == $past(rem_idx) + IW'(1)); // R4

  AST_UPD_READY: assert property (@(posedge clk) disable iff (rst)
    upd_rdy == (occ_c != '0)); // R3

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
    !(a_fire && !r_fire && occ_c == CW'(DEPTH))); // R5

  AST_FULL_SWAP: assert property (@(posedge clk) disable iff (rst)
    (occ_c == CW'(DEPTH) && r_fire) |-> alloc_rdy); // R5

  AST_FULL_BLOCK: assert property (@(posedge clk) disable iff (rst)
    (occ_c == CW'(DEPTH) && !r_fire) |-> !alloc_rdy); // R5
endmodule

bind reorder_buf reorder_buf_checker #(.DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst(rst), .alloc_en(alloc_en), .alloc_rdy(alloc_rdy),
  .alloc_idx(alloc_idx), .upd_rdy(upd_rdy), .rem_en(rem_en),
  .rem_rdy(rem_rdy), .rem_idx(rem_idx)
);

// File: tb/sim_reorder_buf.sv
`timescale 1ns/1ps
module sim_reorder_buf;
  localparam int DEPTH = 8;
  localparam int DW = 16;
  localparam int IW = $clog2(DEPTH);

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          alloc_en = 1'b0, upd_en = 1'b0, rem_en = 1'b0;
  logic [IW-1:0] upd_idx = '0;
  logic [DW-1:0] upd_data = '0;
  logic          alloc_rdy, upd_rdy, rem_rdy;
  logic [IW-1:0] alloc_idx, rem_idx;
  logic [DW-1:0] rem_data;

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  // reference model
  bit          m_vld [DEPTH];
  bit          m_done [DEPTH];
  logic [DW-1:0] m_data [DEPTH];
  int          m_head, m_tail, m_cnt;

  always #4 clk = ~clk;

  reorder_buf #(.DEPTH(DEPTH), .DW(DW)) u0 (
    .clk(clk), .rst(rst),
    .alloc_en(alloc_en), .alloc_rdy(alloc_rdy), .alloc_idx(alloc_idx),
    .upd_en(upd_en), .upd_rdy(upd_rdy), .upd_idx(upd_idx), .upd_data(upd_data),
    .rem_en(rem_en), .rem_rdy(rem_rdy), .rem_idx(rem_idx), .rem_data(rem_data)
  );

  task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  function automatic bit exp_rem_rdy();
    return m_vld[m_head] && m_done[m_head];
  endfunction

  function automatic bit exp_alloc_rdy(input bit re);
    return (m_cnt != DEPTH) || (re && exp_rem_rdy());
  endfunction

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; alloc_en = 0; upd_en = 0; rem_en = 0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    for (int i = 0; i < DEPTH; i++) begin m_vld[i] = 0; m_done[i] = 0; end
    m_head = 0; m_tail = 0; m_cnt = 0;
    #1;
    chk("R1", "alloc_rdy", alloc_rdy, 1);
    chk("R1", "upd_rdy", upd_rdy, 0);
    chk("R1", "rem_rdy", rem_rdy, 0);
    chk("R1", "alloc_idx", alloc_idx, 0);
    chk("R1", "rem_idx", rem_idx, 0);
  endtask

  // one cycle: drive at the falling edge, check outputs, advance the model
  task automatic step(input bit ae, input bit ue, input int ui, input logic [DW-1:0] ud,
                      input bit re, input string tag);
    bit e_ar, e_ur, e_rr, af, uf, rf, byp;
    logic [DW-1:0] e_rd;
    string t;
    @(negedge clk);
    alloc_en = ae; upd_en = ue; upd_idx = IW'(ui); upd_data = ud; rem_en = re;
    #1;
    e_rr = exp_rem_rdy();
    e_ur = (m_cnt != 0);
    e_ar = exp_alloc_rdy(re);
    t = (tag != "") ? tag : ((m_cnt == DEPTH) ? "R5" : "R2");
    chk(t, "alloc_rdy", alloc_rdy, e_ar);
    chk((tag != "") ? tag : "R2", "alloc_idx", alloc_idx, m_tail);
    chk((tag != "") ? tag : "R3", "upd_rdy", upd_rdy, e_ur);
    chk((tag != "") ? tag : "R4", "rem_rdy", rem_rdy, e_rr);
    chk((tag != "") ? tag : "R4", "rem_idx", rem_idx, m_head);
    uf = ue && e_ur && m_vld[ui];
    byp = uf && (ui == m_head);
    if (e_rr) begin
      e_rd = byp ? ud : m_data[m_head];
      chk((tag != "") ? tag : (byp ? "R6" : "R4"), "rem_data", rem_data, e_rd);
    end
    af = ae && e_ar;
    rf = re && e_rr;
    if (uf) begin m_done[ui] = 1; m_data[ui] = ud; end
    if (rf) begin
      m_vld[m_head] = 0; m_done[m_head] = 0;
      m_head = (m_head + 1) % DEPTH;
    end
    if (af) begin
      m_vld[m_tail] = 1; m_done[m_tail] = 0;
      m_tail = (m_tail + 1) % DEPTH;
    end
    m_cnt = m_cnt + (af ? 1 : 0) - (rf ? 1 : 0);
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    #(8 * 150000);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
    end
  end

  initial begin
    void'($urandom(32'd20251));
    do_reset();

    // R5: fill, then a full buffer must refuse allocate without a remove
    for (int i = 0; i < DEPTH; i++) step(1, 0, 0, 0, 0, "R2");
    step(1, 0, 0, 0, 0, "R5");
    step(1, 0, 0, 0, 0, "R5");
    // R6: update the oldest slot; remove not ready in that same cycle
    step(0, 1, 0, 16'hA5A5, 1, "R6");
    step(0, 0, 0, 0, 0, "R6");
    // R5: full, remove and allocate together
    step(1, 0, 0, 0, 1, "R5");
    step(0, 0, 0, 0, 0, "R5");
    // R6: rewrite the oldest (already done) slot while removing it -> new value
    step(0, 1, 1, 16'h1111, 0, "R6");
    step(0, 1, 1, 16'h2222, 1, "R6");
    // R8: update, remove and allocate in one cycle
    step(0, 1, 2, 16'h3333, 0, "R8");
    step(1, 1, 3, 16'h4444, 1, "R8");
    step(1, 1, 4, 16'h5555, 1, "R8");
    step(0, 0, 0, 0, 0, "R8");

    // R7: update to a free slot is ignored
    do_reset();
    step(1, 0, 0, 0, 0, "R7");
    step(0, 1, 5, 16'hDEAD, 0, "R7");
    step(0, 0, 0, 0, 1, "R7");
    step(0, 1, 0, 16'h0042, 0, "R7");
    step(0, 0, 0, 0, 1, "R7");
    step(0, 0, 0, 0, 0, "R7");
    // R4: remove enable while not ready changes nothing
    step(1, 0, 0, 0, 1, "R4");
    step(0, 0, 0, 0, 1, "R4");
    step(0, 0, 0, 0, 0, "R4");

    // constrained random traffic
    do_reset();
    for (int n = 0; n < 4000; n++) begin
      int ui;
      bit ae, ue, re;
      ae = ($urandom % 4) != 0;
      ue = ($urandom % 3) != 0;
      re = ($urandom % 3) != 0;
      if (m_cnt > 0 && ($urandom % 8) != 0) ui = (m_head + int'($urandom % m_cnt)) % DEPTH;
      else ui = int'($urandom % DEPTH);
      step(ae, ue, ui, DW'($urandom), re, "");
    end

    do_reset();
    finished = 1'b1;
    summary();
  end
endmodule